// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit works out where one instruction operand lives. Decode hands it a mode code, the index of a first register, the contents of two registers read from the register file, the program counter, a 16-bit displacement and the operand size. One cycle later the unit gives back one of three things: the effective address, the immediate value, or (for a register operand) the register index together with an is-register flag.

Two of the modes step a register up or down by the operand size. For those the unit also raises a one-cycle request to write the stepped value back to that register. The memory-indirect mode works differently. The unit issues one read through a valid/ready request channel, waits for the response, and returns the fetched word as the effective address. While that fetch is in flight the unit takes no new operand.

The register file, the memory and the decoder all sit outside the unit. All address arithmetic wraps modulo 2^ADDR_W.

Top module: `operandLocator`

## Requirements
- R1: After reset, resValid, wbValid, illegalMode and memReqValid are low and reqReady is high.
- R2: Mode code 0 (immediate): the cycle after the operand is accepted, resValid is high, resValue is the sign-extended displacement and resIsReg is low.
- R3: Mode code 1 (register): resValid is high with resIsReg high, and resValue is the zero-extended index regIdx.
- R4: Mode code 2 (absolute): resValue is the displacement zero-extended. Mode code 3 (register indirect): resValue is regAVal.
- R5: Mode codes 5, 6 and 7 give regAVal + sext(disp), regAVal + regBVal and regAVal + regBVal + sext(disp) respectively. Each sum wraps modulo 2^32.
- R6: Mode code 8 (relative): resValue is pc + sext(disp), so a negative displacement reaches below pc.
- R7: Mode code 9 (post-increment): resValue is regAVal, and the write-back value is regAVal + step. The step is 1, 2 or 4 for opSize 0, 1 or 2, and opSize 3 counts as 4.
- R8: Mode code 10 (pre-decrement): the write-back value is regAVal - step, and resValue equals that same decremented value.
- R9: wbValid is high for exactly the one result cycle, and only for mode codes 9 and 10. In that cycle wbIdx equals regIdx.
- R10: Mode code 4 (memory indirect): the cycle after acceptance, memReqValid rises with memReqAddr equal to the zero-extended displacement. The request is held unchanged until memReqReady, and reqReady stays low until the response arrives.
- R11: For mode code 4, resValid rises only in the cycle after memRspValid is accepted. In that cycle resValue equals memRspData and no write-back is raised.
- R12: Mode codes 11 to 15 raise illegalMode for one cycle. They produce neither resValid nor wbValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | An operand is presented |
| reqReady | output | 1 | Unit can accept an operand |
| mode | input | 4 | Addressing mode code |
| regIdx | input | IDX_W | Index of the first register |
| regAVal | input | ADDR_W | Contents of the first register |
| regBVal | input | ADDR_W | Contents of the second register |
| pc | input | ADDR_W | Program counter |
| disp | input | DISP_W | Displacement / address / immediate field |
| opSize | input | 2 | Operand size: 0 byte, 1 half, 2 word |
| resValid | output | 1 | Result pulse |
| resValue | output | ADDR_W | Effective address, immediate, or register index |
| resIsReg | output | 1 | Operand is a register |
| illegalMode | output | 1 | Unused mode code seen |
| wbValid | output | 1 | Register write-back request |
| wbIdx | output | IDX_W | Write-back register index |
| wbData | output | ADDR_W | Write-back value |
| memReqValid | output | 1 | Pointer read request |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | ADDR_W | Pointer read address |
| memRspValid | input | 1 | Pointer word returned |
| memRspData | input | ADDR_W | Returned pointer word |

## Verification
The bench builds the unit with its defaults: 32-bit addresses, a 16-bit displacement and 4-bit register indices. A 16-bit field is narrow enough that random displacements often have the sign bit set, so sign extension and relative targets below the program counter come up regularly. With 32-bit register values near zero or all ones, the increment, decrement and two-register sums carry across the 2^32 boundary. Random request and response delays of zero to three cycles also exercise the memory-indirect channel, including requests that are taken at once and requests that are held.

// File: rtl/olPkg.sv
package olPkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_IMM   = 4'd0,
    M_REG   = 4'd1,
    M_ABS   = 4'd2,
    M_RIND  = 4'd3,
    M_MIND  = 4'd4,
    M_IDX   = 4'd5,
    M_BIDX  = 4'd6,
    M_BIDXO = 4'd7,
    M_REL   = 4'd8,
    M_AINC  = 4'd9,
    M_ADEC  = 4'd10
  } modeE;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_MREQ  = 2'd1,
    S_MWAIT = 2'd2
  } stateE;

  typedef struct packed {
    logic capture;
    logic takeRsp;
  } strobeT;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    return m <= M_ADEC;
  endfunction
endpackage

// File: rtl/olDatapath.sv
module olDatapath
  import olPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] regAVal,
  input  logic [ADDR_W-1:0] regBVal,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        opSize,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] resValue,
  output logic              resIsReg,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [ADDR_W-1:0] wbData,
  output logic [ADDR_W-1:0] memReqAddr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispSext;
  logic [ADDR_W-1:0] dispZext;
  logic [ADDR_W-1:0] idxZext;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] decVal;
  logic [ADDR_W-1:0] eaNext;
  logic [ADDR_W-1:0] wbNext;
  logic              isRegNext;

  always_comb begin
    dispSext = {{EXT_W{disp[DISP_W-1]}}, disp};
    dispZext = {{EXT_W{1'b0}}, disp};
    idxZext  = {{(ADDR_W-IDX_W){1'b0}}, regIdx};
    case (opSize)
      2'd0:    step = ADDR_W'(1);
      2'd1:    step = ADDR_W'(2);
      default: step = ADDR_W'(4);
    endcase
    decVal    = regAVal - step;
    eaNext    = '0;
    wbNext    = regAVal;
    isRegNext = 1'b0;
    case (mode)
      M_IMM:   eaNext = dispSext;
      M_REG:   begin eaNext = idxZext; isRegNext = 1'b1; end
      M_ABS:   eaNext = dispZext;
      M_RIND:  eaNext = regAVal;
      M_MIND:  eaNext = dispZext;
      M_IDX:   eaNext = regAVal + dispSext;
      M_BIDX:  eaNext = regAVal + regBVal;
      M_BIDXO: eaNext = regAVal + regBVal + dispSext;
      M_REL:   eaNext = pc + dispSext;
      M_AINC:  begin eaNext = regAVal; wbNext = regAVal + step; end
      M_ADEC:  begin eaNext = decVal; wbNext = decVal; end
      default: eaNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValue   <= '0;
      resIsReg   <= 1'b0;
      wbIdx      <= '0;
      wbData     <= '0;
      memReqAddr <= '0;
    end else if (strobe.takeRsp) begin
      resValue <= memRspData;
      resIsReg <= 1'b0;
    end else if (strobe.capture) begin
      resValue   <= eaNext;
      resIsReg   <= isRegNext;
      wbIdx      <= regIdx;
      wbData     <= wbNext;
      memReqAddr <= dispZext;
    end
  end

  assert_rsp_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRsp |=> resValue == $past(memRspData));

  assert_dec_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && mode == M_ADEC) |=> wbData == resValue);

  assert_inc_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && mode == M_AINC) |=> (wbData - resValue) == $past(step));
endmodule

// File: rtl/olControl.sv
module olControl
  import olPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [MODE_W-1:0] mode,
  input  logic              memReqReady,
  input  logic              memRspValid,
  output logic              reqReady,
  output logic              resValid,
  output logic              wbValid,
  output logic              illegalMode,
  output logic              memReqValid,
  output strobeT            strobe
);
  stateE state;
  stateE stateNext;
  logic  fire;
  logic  isLegal;
  logic  isAuto;
  logic  isMind;

  always_comb begin
    isLegal     = modeLegal(mode);
    isAuto      = (mode == M_AINC) || (mode == M_ADEC);
    isMind      = (mode == M_MIND);
    reqReady    = (state == S_IDLE);
    memReqValid = (state == S_MREQ);
    fire        = reqReady && reqValid;
    strobe.capture = fire && isLegal;
    strobe.takeRsp = (state == S_MWAIT) && memRspValid;
    stateNext = state;
    case (state)
      S_IDLE:  if (fire && isMind) stateNext = S_MREQ;
      S_MREQ:  if (memReqReady) stateNext = S_MWAIT;
      S_MWAIT: if (memRspValid) stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      resValid    <= 1'b0;
      wbValid     <= 1'b0;
      illegalMode <= 1'b0;
    end else begin
      state       <= stateNext;
      resValid    <= (strobe.capture && !isMind) || strobe.takeRsp;
      wbValid     <= strobe.capture && isAuto;
      illegalMode <= fire && !isLegal;
    end
  end

  assert_wb_auto_R9: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> $past(fire && isAuto));

  assert_illegal_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    illegalMode |-> (!resValid && !wbValid));

  assert_rsp_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MWAIT && memRspValid) |=> (resValid && !wbValid));
endmodule

// File: rtl/operandLocator.sv
module operandLocator
  import olPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        mode,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [ADDR_W-1:0] regAVal,
  input  logic [ADDR_W-1:0] regBVal,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]        opSize,
  output logic              resValid,
  output logic [ADDR_W-1:0] resValue,
  output logic              resIsReg,
  output logic              illegalMode,
  output logic              wbValid,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [ADDR_W-1:0] wbData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);
  strobeT strobe;

  olControl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode(mode),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .reqReady(reqReady), .resValid(resValid), .wbValid(wbValid),
    .illegalMode(illegalMode), .memReqValid(memReqValid), .strobe(strobe)
  );

  olDatapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode), .regIdx(regIdx),
    .regAVal(regAVal), .regBVal(regBVal), .pc(pc), .disp(disp),
    .opSize(opSize), .memRspData(memRspData), .resValue(resValue),
    .resIsReg(resIsReg), .wbIdx(wbIdx), .wbData(wbData),
    .memReqAddr(memReqAddr)
  );

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/sim_operandLocator.sv
module sim_operandLocator;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  mode = '0;
  logic [3:0]  regIdx = '0;
  logic [31:0] regAVal = '0, regBVal = '0, pc = '0;
  logic [15:0] disp = '0;
  logic [1:0]  opSize = '0;
  logic        resValid, resIsReg, illegalMode, wbValid, memReqValid;
  logic [31:0] resValue, wbData, memReqAddr;
  logic [3:0]  wbIdx;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  operandLocator u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] stepOf(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic [31:0] expEa(input logic [3:0] m, input logic [3:0] ix,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] p,
      input logic [15:0] d, input logic [1:0] s);
    case (m)
      4'd0: return sx(d);
      4'd1: return {28'd0, ix};
      4'd2: return {16'd0, d};
      4'd3: return a;
      4'd5: return a + sx(d);
      4'd6: return a + b;
      4'd7: return a + b + sx(d);
      4'd8: return p + sx(d);
      4'd9: return a;
      4'd10: return a - stepOf(s);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] m);
    case (m)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic runOp(input logic [3:0] m, input logic [3:0] ix, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] p, input logic [15:0] d, input logic [1:0] s,
      input int reqDly, input int rspDly, input logic [31:0] ptr);
    @(negedge clk);
    check("R10 ready before accept", {31'd0, reqReady}, 32'd1);
    mode = m; regIdx = ix; regAVal = a; regBVal = b; pc = p; disp = d; opSize = s;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (m == 4'd4) begin
      check("R10 req valid", {31'd0, memReqValid}, 32'd1);
      check("R10 req addr", memReqAddr, {16'd0, d});
      check("R10 busy", {31'd0, reqReady}, 32'd0);
      check("R11 no early result", {31'd0, resValid}, 32'd0);
      for (int i = 0; i < reqDly; i++) begin
        @(negedge clk);
        check("R10 req held", {31'd0, memReqValid}, 32'd1);
        check("R10 addr held", memReqAddr, {16'd0, d});
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      check("R10 req dropped", {31'd0, memReqValid}, 32'd0);
      for (int i = 0; i < rspDly; i++) begin
        check("R11 waiting", {31'd0, resValid}, 32'd0);
        check("R10 busy wait", {31'd0, reqReady}, 32'd0);
        @(negedge clk);
      end
      memRspValid = 1'b1; memRspData = ptr;
      @(negedge clk);
      memRspValid = 1'b0;
      check("R11 result valid", {31'd0, resValid}, 32'd1);
      check("R11 pointer value", resValue, ptr);
      check("R11 not reg", {31'd0, resIsReg}, 32'd0);
      check("R11 no wb", {31'd0, wbValid}, 32'd0);
    end else if (m > 4'd10) begin
      check("R12 illegal flag", {31'd0, illegalMode}, 32'd1);
      check("R12 no result", {31'd0, resValid}, 32'd0);
      check("R12 no wb", {31'd0, wbValid}, 32'd0);
    end else begin
      check({tagOf(m), " valid"}, {31'd0, resValid}, 32'd1);
      check({tagOf(m), " value"}, resValue, expEa(m, ix, a, b, p, d, s));
      check("R3 is-reg flag", {31'd0, resIsReg}, {31'd0, m == 4'd1});
      check("R9 wb only auto", {31'd0, wbValid}, {31'd0, (m == 4'd9 || m == 4'd10)});
      if (m == 4'd9) check("R7 wb data", wbData, a + stepOf(s));
      if (m == 4'd10) check("R8 wb data", wbData, a - stepOf(s));
      if (m == 4'd9 || m == 4'd10) check("R9 wb idx", {28'd0, wbIdx}, {28'd0, ix});
      check("R12 legal quiet", {31'd0, illegalMode}, 32'd0);
    end
    @(negedge clk);
    check("R9 pulse ends", {30'd0, resValid, wbValid}, 32'd0);
    check("R12 pulse ends", {31'd0, illegalMode}, 32'd0);
  endtask

  function automatic logic [31:0] pickVal(input int unsigned r);
    case (r % 5)
      0: return 32'hFFFF_FFFF - (r % 7);
      1: return r % 9;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 resValid", {31'd0, resValid}, 32'd0);
    check("R1 wbValid", {31'd0, wbValid}, 32'd0);
    check("R1 memReqValid", {31'd0, memReqValid}, 32'd0);
    check("R1 illegal", {31'd0, illegalMode}, 32'd0);
    check("R1 reqReady", {31'd0, reqReady}, 32'd1);
    rstN = 1'b1;
    // directed corners
    runOp(4'd0, 4'd2, 0, 0, 0, 16'h8001, 0, 0, 0, 0);            // R2 negative immediate
    runOp(4'd1, 4'd13, 32'h5, 0, 0, 0, 0, 0, 0, 0);              // R3
    runOp(4'd2, 0, 0, 0, 0, 16'hF000, 0, 0, 0, 0);               // R4 zero-extend
    runOp(4'd8, 0, 0, 0, 32'h100, 16'hFFF0, 0, 0, 0, 0);         // R6 backward
    runOp(4'd7, 0, 32'hFFFF_FFF0, 32'h8, 0, 16'h0010, 0, 0, 0, 0); // R5 wrap
    runOp(4'd9, 4'd3, 32'hFFFF_FFFE, 0, 0, 0, 2'd2, 0, 0, 0);    // R7 wrap
    runOp(4'd9, 4'd4, 32'h10, 0, 0, 0, 2'd3, 0, 0, 0);           // R7 size 3
    runOp(4'd10, 4'd5, 32'h0, 0, 0, 0, 2'd0, 0, 0, 0);           // R8 wrap below zero
    runOp(4'd10, 4'd6, 32'h20, 0, 0, 0, 2'd1, 0, 0, 0);          // R8 half
    runOp(4'd15, 4'd1, 32'h20, 0, 0, 0, 2'd0, 0, 0, 0);          // R12
    runOp(4'd4, 0, 0, 0, 0, 16'hABCD, 0, 0, 0, 32'hDEAD_BEEF);   // R10/R11 no delay
    runOp(4'd4, 0, 0, 0, 0, 16'h1234, 0, 3, 3, 32'h0BAD_F00D);   // R10/R11 delays
    for (int n = 0; n < 400; n++) begin
      runOp(4'($urandom_range(0, 15)), 4'($urandom()), pickVal($urandom()),
            pickVal($urandom()), $urandom(), 16'($urandom()), 2'($urandom()),
            $urandom_range(0, 3), $urandom_range(0, 3), $urandom());
    end
    finished = 1;
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule